// File: doc/BRIEF.md
# Halt-on-Zero Program Sequencer

This block is the program-counter and control sequencer of a small CPU that uses 5-bit opcodes. Each cycle it looks at the opcode fetched from the current fetch address and chooses the next address. Most opcodes step the address by one. Opcodes in the control-flow group load a jump target, call a subroutine through a private hardware return stack, return from one, or pulse a strobe that tells the register file to clear itself. The ALU, the register file and the instruction memory are outside this block.

The all-zero opcode halts the core. The incrementer adds the OR of all effective opcode bits, so a zero opcode leaves the address unchanged. A start or trap pulse forces the increment carry-in high, which steps past a halt and resumes execution. One opcode means "issue the previously executed opcode again". It uses the target and condition presented in the current cycle. Once reset is released the core stays halted until the first start pulse.

Top module: `hz_pc_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, the fetch address is 0, the core is halted, the clear strobe is low, both stack error flags are low, the return stack is empty and the remembered previous opcode is 00000.
- R2: While halted, the opcode, target and condition inputs are ignored and the fetch address holds. A start pulse while halted advances the address by exactly one and sets running.
- R3: While running, opcode 00000 holds the fetch address and clears running. If start is high in the same cycle, the address advances by one instead and the core keeps running.
- R4: While running, any opcode not listed in R3, R5 to R7 or R10 advances the fetch address by one, wrapping from 255 to 0.
- R5: Opcode 10011 loads the target into the fetch address. Opcode 10010 loads the target when the condition input is 1 and otherwise advances by one.
- R6: Opcode 10100 drives the clear strobe high for exactly the next cycle and advances the address by one. The strobe is low at all other times.
- R7: Opcode 10101 (call) pushes the fetch address plus one onto an 8-entry return stack and loads the target. Opcode 10110 (return) pops the most recent entry into the fetch address, in last-in first-out order.
- R8: A call while the stack holds 8 entries still loads the target but leaves the stack unchanged, and it sets an overflow flag that stays set until reset.
- R9: A return while the stack is empty advances the address by one, leaves the stack empty, and sets an underflow flag that stays set until reset.
- R10: Opcode 10111 (repeat) executes the most recently executed non-repeat opcode, using the current target and condition inputs. After reset that opcode is 00000, so a repeat halts.
- R11: A repeat that directly follows a repeat still reissues the last non-repeat opcode, and a repeat never changes the remembered opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 5 | Opcode fetched from the current fetch address |
| target_i | input | 8 | Jump or call target for the current opcode |
| cond_i | input | 1 | Condition for the conditional jump |
| start_i | input | 1 | Start or trap pulse; forces the increment carry-in |
| fetch_addr_o | output | 8 | Current instruction pointer |
| running_o | output | 1 | 1 while executing, 0 while halted |
| clr_regs_o | output | 1 | One-cycle strobe that clears the register file |
| stk_ovf_o | output | 1 | Sticky return-stack overflow flag |
| stk_unf_o | output | 1 | Sticky return-stack underflow flag |

## Verification
The hardest states to reach from the ports are a full return stack meeting one more call, and a chain of repeats whose remembered opcode is itself a control-flow operation. The bench drives ten calls in a row without returns, then ten returns, so both the overflow and the underflow edge are crossed with known addresses on the stack. It then builds repeat chains after a conditional jump and straight after reset. An exhaustive sweep runs every opcode under every combination of condition and start. A long pseudo-random phase follows, with every output compared each cycle against an arithmetic model of the requirements.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_HLT  = 5'b00000,
        OP_CJMP = 5'b10010,
        OP_JMP  = 5'b10011,
        OP_CLR  = 5'b10100,
        OP_CALL = 5'b10101,
        OP_RET  = 5'b10110,
        OP_REP  = 5'b10111
    } op_e;

endpackage

// File: rtl/hz_op_select.sv
module hz_op_select
    import hz_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           exec_i,
    input  logic [OPW-1:0] op_i,
    output logic [OPW-1:0] eff_o
);

    logic [OPW-1:0] prev_d, prev_q;

    always_comb begin
        eff_o  = (op_i == OP_REP) ? prev_q : op_i;
        prev_d = exec_i ? eff_o : prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= OP_HLT;
        else     prev_q <= prev_d;
    end

    AST_REP_KEEPS_PREV: assert property (@(posedge clk) disable iff (rst)
        (exec_i && op_i == OP_REP) |=> (prev_q == $past(prev_q))); // R11

    AST_PREV_NOT_REP: assert property (@(posedge clk) disable iff (rst)
        prev_q != OP_REP); // R11

endmodule

// File: rtl/hz_ret_stack.sv
module hz_ret_stack #(
    parameter int DEPTH = 8,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] data_i,
    output logic [AW-1:0] top_o,
    output logic          empty_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          unf;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [AW-1:0] mem_d [DEPTH];
    logic [AW-1:0] mem_q [DEPTH];
    logic [IW-1:0] wr_idx, rd_idx;
    logic          full;

    assign full    = (ctl_q.cnt == CW'(DEPTH));
    assign empty_o = (ctl_q.cnt == '0);
    assign wr_idx  = IW'(ctl_q.cnt);
    assign rd_idx  = IW'(ctl_q.cnt - 1'b1);
    assign top_o   = mem_q[rd_idx];
    assign ovf_o   = ctl_q.ovf;
    assign unf_o   = ctl_q.unf;

    always_comb begin
        ctl_d = ctl_q;
        mem_d = mem_q;
        if (push_i) begin
            if (full) begin
                ctl_d.ovf = 1'b1;
            end else begin
                mem_d[wr_idx] = data_i;
                ctl_d.cnt     = ctl_q.cnt + 1'b1;
            end
        end else if (pop_i) begin
            if (empty_o) ctl_d.unf = 1'b1;
            else         ctl_d.cnt = ctl_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            mem_q <= mem_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push_i && full) |=> (ctl_q.cnt == CW'(DEPTH)) && ovf_o); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o) |=> (empty_o && unf_o)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o); // R8

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        unf_o |=> unf_o); // R9

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        ctl_q.cnt <= CW'(DEPTH)); // R7

endmodule

// File: rtl/hz_pc_sequencer.sv
module hz_pc_sequencer
    import hz_pkg::*;
#(
    parameter int AW          = 8,
    parameter int STACK_DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode_i,
    input  logic [AW-1:0]  target_i,
    input  logic           cond_i,
    input  logic           start_i,
    output logic [AW-1:0]  fetch_addr_o,
    output logic           running_o,
    output logic           clr_regs_o,
    output logic           stk_ovf_o,
    output logic           stk_unf_o
);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          run;
        logic          clr;
    } seq_t;

    seq_t           st_d, st_q;
    logic [OPW-1:0] eff;
    logic           step;
    logic           push, pop;
    logic [AW-1:0]  inc;
    logic [AW-1:0]  stk_top;
    logic           stk_empty;

    hz_op_select u_opsel (
        .clk    (clk),
        .rst    (rst),
        .exec_i (st_q.run),
        .op_i   (opcode_i),
        .eff_o  (eff)
    );

    hz_ret_stack #(
        .DEPTH (STACK_DEPTH),
        .AW    (AW)
    ) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .pop_i   (pop),
        .data_i  (inc),
        .top_o   (stk_top),
        .empty_o (stk_empty),
        .ovf_o   (stk_ovf_o),
        .unf_o   (stk_unf_o)
    );

    // Incrementer carry-in: any set opcode bit, or a start/trap pulse.
    assign step = (|eff) | start_i;
    assign inc  = st_q.pc + AW'(1);

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        if (!st_q.run) begin
            if (start_i) begin
                st_d.pc  = inc;
                st_d.run = 1'b1;
            end
        end else begin
            st_d.pc  = st_q.pc + AW'(step);
            st_d.run = step;
            case (eff)
                OP_JMP:  st_d.pc = target_i;
                OP_CJMP: if (cond_i) st_d.pc = target_i;
                OP_CLR:  st_d.clr = 1'b1;
                OP_CALL: begin
                    push    = 1'b1;
                    st_d.pc = target_i;
                end
                OP_RET: begin
                    pop = 1'b1;
                    if (!stk_empty) st_d.pc = stk_top;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fetch_addr_o = st_q.pc;
    assign running_o    = st_q.run;
    assign clr_regs_o   = st_q.clr;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!running_o && !start_i) |=> ($stable(fetch_addr_o) && !running_o)); // R2

    AST_START_RESUME: assert property (@(posedge clk) disable iff (rst)
        (!running_o && start_i) |=> (running_o && fetch_addr_o == $past(fetch_addr_o) + AW'(1))); // R2

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (running_o && opcode_i == OP_HLT && !start_i) |=> ($stable(fetch_addr_o) && !running_o)); // R3

    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (running_o && opcode_i == OP_JMP) |=> (fetch_addr_o == $past(target_i))); // R5

    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (running_o && opcode_i == OP_CLR) |=> clr_regs_o); // R6

    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!running_o) |=> !clr_regs_o); // R6

endmodule

// File: tb/test_hz_pc_sequencer.sv
`timescale 1ns/1ps
module test_hz_pc_sequencer;

    localparam logic [4:0] C_HLT  = 5'b00000;
    localparam logic [4:0] C_CJMP = 5'b10010;
    localparam logic [4:0] C_JMP  = 5'b10011;
    localparam logic [4:0] C_CLR  = 5'b10100;
    localparam logic [4:0] C_CALL = 5'b10101;
    localparam logic [4:0] C_RET  = 5'b10110;
    localparam logic [4:0] C_REP  = 5'b10111;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] opcode = '0;
    logic [7:0] target = '0;
    logic       cond = 1'b0;
    logic       start = 1'b0;
    logic [7:0] fetch_addr;
    logic       running, clr_regs, ovf, unf;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // reference model state
    logic [7:0] m_pc;
    logic       m_run, m_clr, m_ovf, m_unf;
    logic [4:0] m_prev;
    logic [7:0] m_stk [8];
    int         m_cnt;
    bit         m_last_rep;

    always #2.5 clk = ~clk;

    hz_pc_sequencer i_hz_pc_sequencer (
        .clk          (clk),
        .rst          (rst),
        .opcode_i     (opcode),
        .target_i     (target),
        .cond_i       (cond),
        .start_i      (start),
        .fetch_addr_o (fetch_addr),
        .running_o    (running),
        .clr_regs_o   (clr_regs),
        .stk_ovf_o    (ovf),
        .stk_unf_o    (unf)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "fetch_addr", int'(fetch_addr), int'(m_pc));
        chk(tag, "running", int'(running), int'(m_run));
        chk("R6", "clr_regs", int'(clr_regs), int'(m_clr));
        chk("R8", "overflow", int'(ovf), int'(m_ovf));
        chk("R9", "underflow", int'(unf), int'(m_unf));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; opcode = '0;
        @(posedge clk); #1;
        m_pc = '0; m_run = 0; m_clr = 0; m_ovf = 0; m_unf = 0;
        m_prev = C_HLT; m_cnt = 0; m_last_rep = 0;
        compare_all("R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(logic [4:0] op, logic [7:0] tgt, logic c, logic s);
        logic [4:0] eff;
        string      tag;
        @(negedge clk);
        opcode = op; target = tgt; cond = c; start = s;
        eff   = (op == C_REP) ? m_prev : op;
        m_clr = 1'b0;
        if (!m_run) begin
            tag = "R2";
            if (s) begin m_pc = m_pc + 8'd1; m_run = 1'b1; end
        end else begin
            if (op == C_REP) tag = m_last_rep ? "R11" : "R10";
            else if (eff == C_HLT) tag = "R3";
            else if (eff == C_JMP || eff == C_CJMP) tag = "R5";
            else if (eff == C_CLR) tag = "R6";
            else if (eff == C_CALL) tag = (m_cnt == 8) ? "R8" : "R7";
            else if (eff == C_RET) tag = (m_cnt == 0) ? "R9" : "R7";
            else tag = "R4";
            m_last_rep = (op == C_REP);
            m_prev     = eff;
            if (eff == C_HLT) begin
                if (s) m_pc = m_pc + 8'd1; else m_run = 1'b0;
            end else if (eff == C_JMP) begin
                m_pc = tgt;
            end else if (eff == C_CJMP) begin
                m_pc = c ? tgt : m_pc + 8'd1;
            end else if (eff == C_CLR) begin
                m_clr = 1'b1; m_pc = m_pc + 8'd1;
            end else if (eff == C_CALL) begin
                if (m_cnt < 8) begin m_stk[m_cnt] = m_pc + 8'd1; m_cnt++; end
                else m_ovf = 1'b1;
                m_pc = tgt;
            end else if (eff == C_RET) begin
                if (m_cnt > 0) begin m_cnt--; m_pc = m_stk[m_cnt]; end
                else begin m_unf = 1'b1; m_pc = m_pc + 8'd1; end
            end else begin
                m_pc = m_pc + 8'd1;
            end
        end
        @(posedge clk); #1;
        compare_all(tag);
    endtask

    task automatic ensure_running();
        if (!m_run) step(5'd1, 8'd0, 1'b0, 1'b1);
    endtask

    initial begin
        do_reset();

        // R2: halted core ignores every opcode
        for (int op = 0; op < 32; op++) step(5'(op), 8'hA5, 1'b1, 1'b0);
        step(5'd3, 8'h00, 1'b0, 1'b1);

        // exhaustive sweep of opcode x condition x start (R3, R4, R5, R6, R7)
        for (int op = 0; op < 32; op++)
            for (int c = 0; c < 2; c++)
                for (int s = 0; s < 2; s++) begin
                    ensure_running();
                    step(5'(op), 8'(op * 7 + c * 3 + s), 1'(c), 1'(s));
                end

        // R10: repeat straight after reset reissues the halt
        do_reset();
        step(5'd1, 8'd0, 1'b0, 1'b1);
        step(C_REP, 8'h55, 1'b1, 1'b0);

        // R10, R11: repeat chain after a conditional jump
        ensure_running();
        step(C_CJMP, 8'h40, 1'b1, 1'b0);
        step(C_REP, 8'h80, 1'b1, 1'b0);
        step(C_REP, 8'h90, 1'b0, 1'b0);
        step(C_REP, 8'h20, 1'b1, 1'b0);
        step(5'd9, 8'h00, 1'b0, 1'b0);
        step(C_REP, 8'h00, 1'b0, 1'b0);

        // R8, R9: overflow then underflow of the return stack
        do_reset();
        step(5'd1, 8'd0, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) step(C_CALL, 8'(16 * i + 3), 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) step(C_RET, 8'hEE, 1'b0, 1'b0);
        step(C_CALL, 8'h77, 1'b0, 1'b0);
        step(C_RET, 8'h00, 1'b0, 1'b0);

        // R6: back-to-back clear opcodes
        step(C_CLR, 8'h00, 1'b0, 1'b0);
        step(C_CLR, 8'h00, 1'b0, 1'b0);
        step(5'd2, 8'h00, 1'b0, 1'b0);

        // mixed pseudo-random traffic
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            ensure_running();
            step(r[4:0], r[12:5], r[13], (r[17:14] == 4'd0));
        end

        do_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule